// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a clocked static memory with a 32-bit word. It is organised as two 16-bit arrays that see the same address and control. The low array holds bits 0 to 15 and the high array holds bits 16 to 31. Every control and data input is captured on the rising clock edge. Reads come back through a fixed three-stage pipeline. An isolated read therefore takes three clocks. In a burst, the first word takes three clocks and each later word follows one clock after the one before it. The block has no burst counter, so the caller presents a new address, with the address strobe, for every word.

Writes are byte-lane masked. Output enable and sleep act combinationally on the output drive. Sleep also stops accesses from being issued while it is held. Array depth is set by the address-width parameter. A small default keeps simulation fast, and a width of 18 gives the full 256K words.

Top module: `pipeburst_sram`

## Requirements
- R1: The word is 32 bits wide and made of two 16-bit halves at one shared address. Bits 0–15 live in the low half and bits 16–31 in the high half. Writing one half leaves the other half of the same word unchanged.
- R2: An access is issued at a rising edge when the effective chip select is active and sleep is low. The effective chip select is the `ce_n` input on a strobe cycle and the held value otherwise. It is a write when `we_n` is 0 and a read when `we_n` is 1. At most one access is issued per edge.
- R3: `addr` and `ce_n` are loaded into their holding registers only at an edge where `adstrb_n` is 0. At any other edge the held address and held chip select are reused, and a new `addr` or `ce_n` has no effect.
- R4: Read data appears on `dq_out`, with `rd_valid` high, right after the third rising edge that follows the edge that sampled the read. Reads issued on consecutive edges come out on consecutive clocks.
- R5: `lane_we_n[i]` (active low) selects byte lane i, which is bits 8i+7 down to 8i. Only enabled lanes are written. A write with all four lanes disabled changes nothing.
- R6: A read issued on the edge right after a write to the same address returns the newly written word.
- R7: `dq_en` is high exactly when `rd_valid` is high, `oe_n` is 0 and `sleep` is 0. It follows `oe_n` and `sleep` without waiting for a clock.
- R8: While `sleep` is high at an edge, no read or write is issued there. Stored contents are kept, and normal operation resumes at the first edge after sleep falls.
- R9: After reset the held chip select is inactive and `rd_valid` and `dq_en` are 0. No access happens until a strobe cycle selects the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, loaded on strobe cycles |
| wdata | input | 32 | Write data, sampled every edge |
| ce_n | input | 1 | Active-low chip select, loaded on strobe cycles |
| adstrb_n | input | 1 | Active-low address strobe |
| we_n | input | 1 | Active-low global write enable |
| lane_we_n | input | 4 | Active-low per-byte write enables |
| oe_n | input | 1 | Active-low output enable, unclocked |
| sleep | input | 1 | Sleep request, unclocked for the outputs |
| dq_out | output | 32 | Registered read data |
| dq_en | output | 1 | Output drive enable, 0 means high impedance |
| rd_valid | output | 1 | Read word present on dq_out |

## Verification
The bench targets these corner cases:
- **Pipeline depth.** A four-word back-to-back burst checks that each word arrives exactly three edges after issue. A pipeline one stage too short or too long is reported as a latency miss.
- **Address hold.** The bench changes `addr` and `ce_n` while the strobe is high. A design that loads them on every edge would read the wrong word, or stop reading.
- **Lane masking.** Partial-lane writes and a write with every lane disabled are checked. A design that ignores the lane masks corrupts neighbouring bytes.
- **Write-then-read.** A read of the same address on the very next edge exposes a stale-data hazard.
- **Sleep and output enable.** A write issued during sleep must be dropped. A design that lets it through returns the overwritten value. Output enable is toggled while a read is in flight, so a drive enable that ignores `oe_n` or `sleep` is caught on the spot.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int WORD_W         = 32;
  localparam int LANE_W         = 8;
  localparam int N_LANES        = WORD_W / LANE_W;
  localparam int HALVES         = 2;
  localparam int HALF_W         = WORD_W / HALVES;
  localparam int LANES_PER_HALF = N_LANES / HALVES;

  // Expand per-lane enables of one half into a bit mask.
  function automatic logic [HALF_W-1:0] half_lane_mask(input logic [LANES_PER_HALF-1:0] en);
    logic [HALF_W-1:0] m;
    for (int l = 0; l < LANES_PER_HALF; l++)
      m[l*LANE_W +: LANE_W] = {LANE_W{en[l]}};
    return m;
  endfunction

  // Merge new data into an old half word under a lane mask.
  function automatic logic [HALF_W-1:0] half_merge(input logic [HALF_W-1:0] old_w,
                                                   input logic [HALF_W-1:0] new_w,
                                                   input logic [LANES_PER_HALF-1:0] en);
    logic [HALF_W-1:0] m;
    m = half_lane_mask(en);
    return (old_w & ~m) | (new_w & m);
  endfunction
endpackage

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  input  logic                 ce_n,
  input  logic                 adstrb_n,
  input  logic                 we_n,
  input  logic [N_LANES-1:0]   lane_we_n,
  input  logic                 sleep,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [WORD_W-1:0]    wdata_q,
  output logic [N_LANES-1:0]   lane_en_q,
  output logic                 issue_rd,
  output logic                 issue_wr
);
  logic ce_hold;
  logic strobe_now;
  logic ce_now;
  logic go_now;

  assign strobe_now = ~adstrb_n;
  assign ce_now     = strobe_now ? ~ce_n : ce_hold;
  assign go_now     = ce_now & ~sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      ce_hold   <= 1'b0;
      wdata_q   <= '0;
      lane_en_q <= '0;
      issue_rd  <= 1'b0;
      issue_wr  <= 1'b0;
    end else begin
      if (strobe_now) begin
        addr_q  <= addr;
        ce_hold <= ~ce_n;
      end
      wdata_q   <= wdata;
      lane_en_q <= ~lane_we_n;
      issue_rd  <= go_now & we_n;
      issue_wr  <= go_now & ~we_n;
    end
  end

  // R3: the held address does not move on a non-strobe edge
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adstrb_n |=> $stable(addr_q));
  // R2: reads and writes never issue together
  p_one_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_rd && issue_wr));
  // R8: nothing issues from an edge that saw sleep
  p_sleep_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!issue_rd && !issue_wr));
endmodule

// File: rtl/pbs_half_array.sv
module pbs_half_array
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LANES_PER_HALF-1:0]   lane_en,
  input  logic [HALF_W-1:0]           wdata,
  output logic [HALF_W-1:0]           rdata_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [HALF_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[addr] <= half_merge(mem[addr], wdata, lane_en);
    if (rd_en)
      rdata_q <= mem[addr];
  end
endmodule

// File: rtl/pbs_read_pipe.sv
module pbs_read_pipe #(
  parameter int W      = 32,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  input  logic [W-1:0] d_in,
  output logic         v_out,
  output logic [W-1:0] d_out
);
  localparam int DSTG = STAGES - 1;

  logic [STAGES-1:0] v_s;
  logic [W-1:0]      d_s [DSTG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_s <= '0;
    else        v_s <= {v_s[STAGES-2:0], v_in};
  end

  always_ff @(posedge clk) begin
    d_s[0] <= d_in;
    for (int s = 1; s < DSTG; s++)
      d_s[s] <= d_s[s-1];
  end

  assign v_out = v_s[STAGES-1];
  assign d_out = d_s[DSTG-1];
endmodule

// File: rtl/pipeburst_sram.sv
module pipeburst_sram
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  input  logic                ce_n,
  input  logic                adstrb_n,
  input  logic                we_n,
  input  logic [3:0]          lane_we_n,
  input  logic                oe_n,
  input  logic                sleep,
  output logic [31:0]         dq_out,
  output logic                dq_en,
  output logic                rd_valid
);
  localparam int PIPE_STAGES = 3;

  logic [ADDR_W-1:0]  addr_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [N_LANES-1:0] lane_en_q;
  logic               issue_rd;
  logic               issue_wr;
  logic [WORD_W-1:0]  array_q;

  pbs_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n),
    .adstrb_n(adstrb_n), .we_n(we_n), .lane_we_n(lane_we_n), .sleep(sleep),
    .addr_q(addr_q), .wdata_q(wdata_q), .lane_en_q(lane_en_q),
    .issue_rd(issue_rd), .issue_wr(issue_wr)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    pbs_half_array #(.ADDR_W(ADDR_W)) half_i (
      .clk(clk), .wr_en(issue_wr), .rd_en(issue_rd), .addr(addr_q),
      .lane_en(lane_en_q[h*LANES_PER_HALF +: LANES_PER_HALF]),
      .wdata(wdata_q[h*HALF_W +: HALF_W]),
      .rdata_q(array_q[h*HALF_W +: HALF_W])
    );
  end

  pbs_read_pipe #(.W(WORD_W), .STAGES(PIPE_STAGES)) pipe_i (
    .clk(clk), .rst_n(rst_n), .v_in(issue_rd), .d_in(array_q),
    .v_out(rd_valid), .d_out(dq_out)
  );

  assign dq_en = rd_valid & ~oe_n & ~sleep;

  // R4: every valid word traces back to a read issued three edges earlier
  p_lat_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(issue_rd, 3));
  // R4: every issued read surfaces three edges later
  p_lat_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue_rd, 3) |-> rd_valid);
  // R8: outputs are released while sleeping
  p_sleep_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_en);
endmodule

// File: tb/pipeburst_sram_tb_top.sv
module pipeburst_sram_tb_top;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          ce_n = 1'b1, adstrb_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [3:0]    lane_we_n = 4'hF;
  logic [31:0]   dq_out;
  logic          dq_en, rd_valid;

  int n_chk = 0, n_bad = 0, cyc_n = 0;
  logic [31:0] mdl [int];
  logic [AW-1:0] h_addr = '0;
  logic h_ce = 1'b0;
  int          q_due [$];
  logic [31:0] q_dat [$];
  string       q_tag [$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  pipeburst_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n),
    .adstrb_n(adstrb_n), .we_n(we_n), .lane_we_n(lane_we_n), .oe_n(oe_n),
    .sleep(sleep), .dq_out(dq_out), .dq_en(dq_en), .rd_valid(rd_valid)
  );

  function automatic logic [31:0] lane_apply(logic [31:0] o, logic [31:0] n, logic [3:0] wen);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (!wen[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (edge %0d)", tag, act, exp, cyc_n);
    end
  endtask

  // Driver: one cycle of stimulus, model update, expectation push.
  task automatic op(logic strb, logic cen, logic [AW-1:0] a, logic wen,
                    logic [3:0] lwe, logic [31:0] d, logic oe, logic slp, string tag);
    logic ce_eff;
    logic [AW-1:0] a_eff;
    int edge_no;
    @(negedge clk);
    adstrb_n = strb; ce_n = cen; addr = a; we_n = wen; lane_we_n = lwe;
    wdata = d; oe_n = oe; sleep = slp;
    edge_no = cyc_n + 1;
    ce_eff = !strb ? !cen : h_ce;
    a_eff  = !strb ? a : h_addr;
    if (!strb) begin h_addr = a; h_ce = !cen; end
    if (ce_eff && !slp) begin
      if (!wen) begin
        mdl[int'(a_eff)] = lane_apply(mdl.exists(int'(a_eff)) ? mdl[int'(a_eff)] : 32'h0, d, lwe);
      end else begin
        q_due.push_back(edge_no + 3);
        q_dat.push_back(mdl.exists(int'(a_eff)) ? mdl[int'(a_eff)] : 32'h0);
        q_tag.push_back(tag);
      end
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [3:0] lwe);
    op(1'b0, 1'b0, a, 1'b0, lwe, d, 1'b0, 1'b0, "R2");
  endtask
  task automatic rd(logic [AW-1:0] a, string tag);
    op(1'b0, 1'b0, a, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0, tag);
  endtask
  task automatic idle(int n, logic oe);
    for (int i = 0; i < n; i++) op(1'b0, 1'b1, '0, 1'b1, 4'hF, 32'h0, oe, 1'b0, "R9");
  endtask

  // Monitor: sample mid-high phase, away from both the edge and the driver.
  initial begin
    forever begin
      @(posedge clk); #3;
      if (rst_n) begin
        check(dq_en === (rd_valid & !oe_n & !sleep), "R7 dq_en", {31'b0, dq_en},
              {31'b0, rd_valid & !oe_n & !sleep});
        while (q_due.size() > 0 && q_due[0] < cyc_n) begin
          check(1'b0, {q_tag[0], " missing read word"}, 32'h0, q_dat[0]);
          void'(q_due.pop_front()); void'(q_dat.pop_front()); void'(q_tag.pop_front());
        end
        if (rd_valid) begin
          if (q_due.size() == 0 || q_due[0] != cyc_n) begin
            check(1'b0, "R4 unexpected rd_valid", dq_out, 32'h0);
          end else begin
            check(dq_out === q_dat[0], {q_tag[0], " read data"}, dq_out, q_dat[0]);
            void'(q_due.pop_front()); void'(q_dat.pop_front()); void'(q_tag.pop_front());
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #3;
    check(rd_valid === 1'b0, "R9 reset rd_valid", {31'b0, rd_valid}, 32'h0);
    check(dq_en === 1'b0, "R9 reset dq_en", {31'b0, dq_en}, 32'h0);
    // R9: no strobe yet, so ce_n low alone must not start reads
    repeat (3) op(1'b1, 1'b0, 10'd5, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0, "R9");
    // R2: full-word writes
    for (int i = 0; i < 8; i++) wr(AW'(i), 32'hA500_0000 ^ (i * 32'h0101_0101), 4'h0);
    // R4: back-to-back burst 3/1/1/1
    for (int i = 0; i < 4; i++) rd(AW'(i), "R4");
    idle(5, 1'b0);
    // R1: halves written independently
    wr(10'd40, 32'h1111_2222, 4'h0);
    wr(10'd40, 32'hABCD_0000, 4'h3);
    wr(10'd41, 32'h3333_4444, 4'h0);
    wr(10'd41, 32'h0000_BEEF, 4'hC);
    rd(10'd40, "R1"); rd(10'd41, "R1");
    idle(4, 1'b0);
    // R5: lane masks, including a write with every lane off
    wr(10'd8, 32'hFFFF_FFFF, 4'h0);
    wr(10'd8, 32'h1122_3344, 4'hA);
    wr(10'd8, 32'h0000_0000, 4'hF);
    rd(10'd8, "R5");
    idle(4, 1'b0);
    // R6: write then immediate read of the same word
    wr(10'd30, 32'hC0FF_EE00, 4'h0);
    rd(10'd30, "R6");
    wr(10'd30, 32'h0BAD_F00D, 4'h0);
    rd(10'd30, "R6");
    idle(4, 1'b0);
    // R3: address and select held while strobe is high
    rd(10'd2, "R3");
    op(1'b1, 1'b1, 10'd7, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0, "R3");
    op(1'b1, 1'b1, 10'd6, 1'b1, 4'hF, 32'h0, 1'b0, 1'b0, "R3");
    idle(5, 1'b0);
    // R7: oe_n high while a read is in flight
    rd(10'd1, "R7");
    idle(2, 1'b1);
    op(1'b0, 1'b1, '0, 1'b1, 4'hF, 32'h0, 1'b1, 1'b0, "R7");
    idle(3, 1'b0);
    // R8: sleep drops a write and a read, contents survive
    op(1'b0, 1'b0, 10'd3, 1'b0, 4'h0, 32'hDEAD_DEAD, 1'b0, 1'b1, "R8");
    op(1'b0, 1'b0, 10'd3, 1'b1, 4'hF, 32'h0, 1'b0, 1'b1, "R8");
    op(1'b0, 1'b1, '0, 1'b1, 4'hF, 32'h0, 1'b0, 1'b1, "R8");
    rd(10'd3, "R8");
    idle(4, 1'b0);
    // R4: mixed interleave of writes and reads
    rd(10'd4, "R4"); wr(10'd9, 32'h5A5A_A5A5, 4'h0); rd(10'd9, "R4"); rd(10'd7, "R4");
    idle(8, 1'b0);
    check(q_due.size() == 0, "R4 drained queue", q_due.size(), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule